// File: doc/BRIEF.md
# Spread-Spectrum Code Acquisition Correlator

This block recovers data from a binary phase-modulated direct-sequence stream. Each data bit is spread over one period of a 15-chip maximal-length pseudo-noise code, and the receiver delivers hard-decided baseband samples, four per chip, each marked by a valid strobe. The block correlates each received code period against a locally generated copy of the code. It then compares the magnitude of the sum with a threshold that the host can program.

While searching, a failed trial retards the local code by half a chip and a new trial starts. A trial that meets the threshold declares lock and freezes the code phase. From then on the block emits one despread bit with a single-cycle strobe at the end of every code period. The sign of the correlation gives the bit. A clear input drops lock and restarts the search from code phase zero.

Top module: `dsss_acq_corr`

## Requirements
- R1: After reset `locked` and `bit_stb` are 0 and the threshold is 0x30 (48), so a trial whose correlation magnitude is 48 locks and one with magnitude 46 does not.
- R2: A sample with `smp_bit`=1 counts as +1 and with `smp_bit`=0 as -1. The local chip is bit 0 of a 4-bit register seeded with 0001. At each chip boundary that register shifts right, and bit 0 XOR bit 1 enters at bit 3 (polynomial x^4+x+1). Chip +1 corresponds to a register bit of 1, and a chip lasts 4 valid samples.
- R3: A trial sums (sample x local chip) over exactly 60 consumed samples, aligned to local chip 0. The result appears in the same clock edge that takes the 60th sample: `locked` and `bit_stb` are visible after that edge. While searching, `bit_stb` stays low on every failed trial.
- R4: After a failed trial the next 2 valid samples are discarded and the local phase holds. Each trial therefore falls 2 samples further behind the received code, so a stream at any even sample offset d locks after trial k = ((60-d)/2) mod 30, i.e. after 62k+60 valid samples.
- R5: A one-cycle `thr_we` loads `thr_din` as an unsigned threshold. Lock requires magnitude >= threshold. Any threshold above 60 never locks, and a threshold of 0 locks on the first trial.
- R6: Once locked the phase no longer slips. `bit_stb` pulses for exactly one cycle after the last sample of every 60-sample period, and at no other time. `bit_val` is 1 when that period's sum is positive and 0 otherwise. This also applies to the period that declared lock.
- R7: An inverted stream (all data bits 0) locks at the same trial as its non-inverted twin, with `bit_val`=0.
- R8: `clr` forces `locked` and `bit_stb` low after the next edge and restarts the code at phase zero. A sample offered in the same cycle as `clr` is discarded, and the threshold is kept.
- R9: Cycles with `smp_vld` low change nothing. A strobe never follows a cycle without a valid sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Drop lock and restart the search |
| smp_vld | input | 1 | Sample valid strobe |
| smp_bit | input | 1 | Hard-decided sample, 1 = +1, 0 = -1 |
| thr_we | input | 1 | Threshold write enable |
| thr_din | input | 8 | Threshold write data (unsigned) |
| locked | output | 1 | Code lock flag |
| bit_stb | output | 1 | One-cycle strobe per despread bit |
| bit_val | output | 1 | Despread bit, valid with `bit_stb` |

## Verification
The bench sweeps every even code offset so that the search order is exercised end to end. A slip in the wrong direction, or by the wrong amount, lands lock on the wrong trial or never reaches it. Odd offsets peak at 44 and must never lock at the default threshold. Flipping 6 versus 7 aligned samples pins the comparison at exactly 48, which exposes a strict inequality or a wrong reset value. Inverted streams and a zero threshold with a negative sum catch a design that compares the signed sum, or that takes the bit from anything other than its sign. Idle gaps between samples, and a sample coinciding with `clr`, catch logic that counts cycles instead of samples or that lets a cleared sample leak into the sum.

// File: rtl/dsss_acq_pkg.sv
package dsss_acq_pkg;

  typedef enum logic {
    ACQ_SEARCH = 1'b0,
    ACQ_LOCK   = 1'b1
  } acq_state_t;

  localparam int SPC_DEF   = 4;
  localparam int CHIPS_DEF = 15;
  localparam int LFSR_DEF  = 4;
  localparam int THR_W_DEF = 8;

endpackage

// File: rtl/dsss_pn_gen.sv
module dsss_pn_gen #(
  parameter int SPC = 4,
  parameter int CHIPS = 15,
  parameter int LFSR_W = 4,
  parameter logic [LFSR_W-1:0] TAP_MASK = 4'b0011,
  parameter logic [LFSR_W-1:0] SEED = 4'b0001
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic adv,
  output logic chip,
  output logic period_end
);
  localparam int SUB_W = (SPC > 1) ? $clog2(SPC) : 1;
  localparam int IDX_W = (CHIPS > 1) ? $clog2(CHIPS) : 1;

  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic              chip_end;
  logic              fb;

  assign chip_end   = (sub_q == SUB_W'(SPC - 1));
  assign period_end = chip_end && (idx_q == IDX_W'(CHIPS - 1));
  assign chip       = lfsr_q[0];
  assign fb         = ^(lfsr_q & TAP_MASK);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sub_q  <= '0;
      idx_q  <= '0;
      lfsr_q <= SEED;
    end else if (adv) begin
      if (chip_end) begin
        sub_q <= '0;
        if (period_end) begin
          idx_q  <= '0;
          lfsr_q <= SEED;
        end else begin
          idx_q  <= idx_q + 1'b1;
          lfsr_q <= {fb, lfsr_q[LFSR_W-1:1]};
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dsss_corr_acc.sv
module dsss_corr_acc #(
  parameter int SUM_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             take,
  input  logic             match,
  input  logic             dump,
  output logic [SUM_W-1:0] sum_now
);
  logic [SUM_W-1:0] acc_q;

  assign sum_now = match ? (acc_q + SUM_W'(1)) : (acc_q - SUM_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc_q <= '0;
    end else if (take) begin
      acc_q <= dump ? '0 : sum_now;
    end
  end

endmodule

// File: rtl/dsss_acq_ctrl.sv
module dsss_acq_ctrl
  import dsss_acq_pkg::*;
#(
  parameter int SUM_W = 7,
  parameter int THR_W = 8,
  parameter int SLIP = 2,
  parameter logic [THR_W-1:0] THR_RST = 8'h30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             smp_vld,
  input  logic             period_end,
  input  logic [SUM_W-1:0] sum_now,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_din,
  output logic             take,
  output logic             locked,
  output logic             bit_stb,
  output logic             bit_val
);
  localparam int STL_W = $clog2(SLIP + 1);
  localparam int CMP_W = SUM_W + THR_W;

  acq_state_t       state_q;
  logic [STL_W-1:0] stall_q;
  logic [THR_W-1:0] thr_q;
  logic [SUM_W-1:0] mag;
  logic             hit;
  logic             positive;

  assign take     = smp_vld && !clr && (stall_q == '0);
  assign mag      = sum_now[SUM_W-1] ? (SUM_W'(0) - sum_now) : sum_now;
  assign hit      = CMP_W'(mag) >= CMP_W'(thr_q);
  assign positive = !sum_now[SUM_W-1] && (sum_now != '0);
  assign locked   = (state_q == ACQ_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= THR_RST;
    end else if (thr_we) begin
      thr_q <= thr_din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= ACQ_SEARCH;
      stall_q <= '0;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      if (smp_vld && (stall_q != '0)) begin
        stall_q <= stall_q - 1'b1;
      end else if (take && period_end) begin
        if ((state_q == ACQ_LOCK) || hit) begin
          state_q <= ACQ_LOCK;
          bit_stb <= 1'b1;
          bit_val <= positive;
        end else begin
          stall_q <= STL_W'(SLIP);
        end
      end
    end
  end

endmodule

// File: rtl/dsss_acq_corr.sv
module dsss_acq_corr
  import dsss_acq_pkg::*;
#(
  parameter int SPC = SPC_DEF,
  parameter int CHIPS = CHIPS_DEF,
  parameter int LFSR_W = LFSR_DEF,
  parameter logic [LFSR_W-1:0] TAP_MASK = 4'b0011,
  parameter logic [LFSR_W-1:0] SEED = 4'b0001,
  parameter int THR_W = THR_W_DEF,
  parameter logic [THR_W-1:0] THR_RST = 8'h30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             smp_vld,
  input  logic             smp_bit,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_din,
  output logic             locked,
  output logic             bit_stb,
  output logic             bit_val
);
  localparam int PERIOD = SPC * CHIPS;
  localparam int SUM_W  = $clog2(PERIOD + 1) + 1;
  localparam int SLIP   = (SPC / 2 > 0) ? SPC / 2 : 1;

  logic             take;
  logic             chip;
  logic             period_end;
  logic [SUM_W-1:0] sum_now;

  dsss_pn_gen #(
    .SPC(SPC), .CHIPS(CHIPS), .LFSR_W(LFSR_W), .TAP_MASK(TAP_MASK), .SEED(SEED)
  ) pn_i (
    .clk(clk), .rst(rst), .restart(clr), .adv(take),
    .chip(chip), .period_end(period_end)
  );

  dsss_corr_acc #(.SUM_W(SUM_W)) acc_i (
    .clk(clk), .rst(rst), .restart(clr), .take(take),
    .match(smp_bit == chip), .dump(period_end), .sum_now(sum_now)
  );

  dsss_acq_ctrl #(
    .SUM_W(SUM_W), .THR_W(THR_W), .SLIP(SLIP), .THR_RST(THR_RST)
  ) ctrl_i (
    .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld),
    .period_end(period_end), .sum_now(sum_now),
    .thr_we(thr_we), .thr_din(thr_din),
    .take(take), .locked(locked), .bit_stb(bit_stb), .bit_val(bit_val)
  );

endmodule

// File: rtl/dsss_acq_chk.sv
module dsss_acq_chk (
  input logic clk,
  input logic rst,
  input logic clr,
  input logic smp_vld,
  input logic locked,
  input logic bit_stb
);
  // R6
  stb_locked_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> locked);

  // R3
  lock_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> bit_stb);

  // R8
  clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!locked && !bit_stb));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !clr) |=> locked);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !bit_stb);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);
endmodule

bind dsss_acq_corr dsss_acq_chk chk_i (
  .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld),
  .locked(locked), .bit_stb(bit_stb)
);

// File: tb/dsss_acq_corr_tb_top.sv
module dsss_acq_corr_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, clr, smp_vld, smp_bit, thr_we;
  logic [7:0] thr_din;
  logic       locked, bit_stb, bit_val;

  dsss_acq_corr dut_i (
    .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .smp_bit(smp_bit),
    .thr_we(thr_we), .thr_din(thr_din),
    .locked(locked), .bit_stb(bit_stb), .bit_val(bit_val)
  );

  int   code [15];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   rp = 0;
  int   nflip = 0;
  int   thr_cur = 48;
  logic data = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_code();
    logic [3:0] s = 4'b0001;
    for (int i = 0; i < 15; i++) begin
      code[i] = int'(s[0]);
      s = {s[0] ^ s[1], s[3:1]};
    end
  endtask

  // Model: trial k at which lock is expected (-1 if none in 31) and bit sign
  task automatic model(input int d, input int thr, input logic pol,
                       output int k_exp, output logic v_exp);
    k_exp = -1;
    v_exp = 1'b0;
    for (int k = 0; k < 31; k++) begin
      int o = (d + 2 * k) % 60;
      int c = 0;
      for (int j = 0; j < 60; j++) begin
        int q = (j + o) % 60;
        int rv = (code[q/4] == 1) ? 1 : -1;
        int lv = (code[j/4] == 1) ? 1 : -1;
        if (!pol) rv = -rv;
        if (q < nflip) rv = -rv;
        c += rv * lv;
      end
      if (((c < 0) ? -c : c) >= thr) begin
        k_exp = k;
        v_exp = (c > 0);
        break;
      end
    end
  endtask

  task automatic next_rx(output logic b);
    b = (code[rp/4] == 1);
    if (!data) b = !b;
    if (rp < nflip) b = !b;
    rp = (rp + 1) % 60;
  endtask

  task automatic step(input logic b);
    smp_vld = 1'b1;
    smp_bit = b;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic write_thr(input int v);
    thr_we  = 1'b1;
    thr_din = 8'(v);
    @(negedge clk);
    thr_we  = 1'b0;
    thr_cur = v;
  endtask

  task automatic run_acq(input int d, input logic pol, input bit gaps, input string req);
    int   k_exp, n, early;
    logic v_exp, b, stb_at, val_at;
    // clear with a stray sample in the same cycle (R8: must be discarded)
    clr = 1'b1; smp_vld = 1'b1; smp_bit = !pol;
    @(negedge clk);
    clr = 1'b0; smp_vld = 1'b0;
    check(!locked && !bit_stb, "R8", int'(locked), 0);
    rp = d; data = pol; n = 0; early = 0; stb_at = 0; val_at = 0;
    model(d, thr_cur, pol, k_exp, v_exp);
    while (n < 62 * 31) begin
      next_rx(b);
      step(b);
      n++;
      if (locked) begin
        stb_at = bit_stb;
        val_at = bit_val;
        break;
      end
      if (bit_stb) early++;
      if (gaps && (n % 3 == 0)) @(negedge clk);
    end
    check(early == 0, "R3", early, 0);
    if (k_exp < 0) begin
      check(!locked, req, int'(locked), 0);
    end else begin
      check(locked && (n == 62 * k_exp + 60), req, n, 62 * k_exp + 60);
      check(stb_at && (val_at == v_exp), "R6", int'(val_at), int'(v_exp));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] pat = 12'b1011_0010_1110;
    logic b;
    build_code();
    rst = 1'b1; clr = 1'b0; smp_vld = 1'b0; smp_bit = 1'b0;
    thr_we = 1'b0; thr_din = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!locked && !bit_stb, "R1", int'(locked), 0);

    // R1: default threshold is exactly 48
    nflip = 6; run_acq(0, 1'b1, 1'b0, "R1");
    nflip = 7; run_acq(0, 1'b1, 1'b0, "R1");
    nflip = 0;

    // R4: every even offset, with idle gaps on some runs (R9)
    for (int d = 0; d < 60; d += 2)
      run_acq(d, 1'b1, (d % 8 == 4), (d % 8 == 4) ? "R9" : "R4");

    // R2: odd offsets peak below the default threshold
    run_acq(1, 1'b1, 1'b0, "R2");
    run_acq(3, 1'b1, 1'b0, "R2");

    // R7: inverted stream
    run_acq(10, 1'b0, 1'b0, "R7");
    run_acq(2, 1'b0, 1'b1, "R7");

    // R5: programmed thresholds
    write_thr(28); run_acq(4, 1'b1, 1'b0, "R5");
    write_thr(29); run_acq(4, 1'b1, 1'b0, "R5");
    write_thr(61); run_acq(0, 1'b1, 1'b0, "R5");
    write_thr(60); run_acq(0, 1'b1, 1'b0, "R5");
    write_thr(0);  run_acq(20, 1'b1, 1'b0, "R5");
    write_thr(48);

    // R6: despread a data pattern after lock
    run_acq(0, 1'b1, 1'b0, "R6");
    for (int i = 11; i >= 0; i--) begin
      int stray = 0;
      data = pat[i];
      for (int j = 0; j < 60; j++) begin
        next_rx(b);
        step(b);
        if (j == 59)
          check(bit_stb && (bit_val == data), "R6", int'(bit_val), int'(data));
        else if (bit_stb)
          stray++;
      end
      check(stray == 0, "R6", stray, 0);
    end
    check(locked, "R6", int'(locked), 1);

    // R8: clear drops lock, threshold kept
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(!locked, "R8", int'(locked), 0);
    run_acq(30, 1'b1, 1'b0, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule